// File: doc/BRIEF.md
# Oversampling Nine-Bit Serial Receiver

This block takes an asynchronous serial line and recovers frames of eleven bit times. Each frame is a low start bit, eight data bits sent least significant first, a ninth bit, and a stop bit. A one-cycle enable, `tick16`, is supplied from outside at sixteen times the bit rate. The receiver counts these ticks to find the middle of each bit. It then decides the bit value from three neighbouring samples, so a single corrupted sample in the middle of a bit does not change the result.

The line first passes through a synchronizer. A high-to-low change on the synchronized line starts a frame, but only while `rx_en` is high. The start is confirmed or abandoned at the middle of the start bit. At the middle of the stop bit the receiver decides whether to keep the frame. It keeps the frame only if the previous one has been collected (`rx_done` low). When `mp_mode` is high, it also requires the stop bit to be high. A kept frame updates the byte and ninth-bit outputs and raises `rx_done`, which stays high until software pulses `done_clr`.

Top module: `nine_bit_rx`

## Requirements
- R1: After reset, `rx_byte` is 0, `rx_bit9` is 0, `rx_done` is 0 and the receiver is idle.
- R2: A frame starts only on a falling edge of the synchronized line while `rx_en` is 1. A frame sent while `rx_en` is 0 leaves all outputs unchanged.
- R3: Bit timing is 16 `tick16` pulses per bit. The tick phase counter restarts at 0 on the detected edge, and phases 7, 8 and 9 are the sample points.
- R4: Each bit value is the majority of its three samples, so one flipped sample per bit does not alter the received data.
- R5: If the start-bit majority is 1, the frame is dropped with no output change, and the receiver waits for the next falling edge.
- R6: The first data bit on the line lands in `rx_byte[0]` and the eighth in `rx_byte[7]`. The bit after the eighth data bit lands in `rx_bit9`.
- R7: A frame is kept only if `rx_done` is 0 at the middle of the stop bit. A dropped frame leaves `rx_byte`, `rx_bit9` and `rx_done` unchanged.
- R8: With `mp_mode` 1, a frame whose stop-bit majority is 0 is dropped. With `mp_mode` 0, the stop-bit value plays no part.
- R9: `rx_done` stays 1 until `done_clr` is 1 at a clock edge. If a frame is kept in the same cycle as a clear, the set wins.
- R10: After the stop-bit decision the receiver is idle at once. A frame that follows with no gap after a full stop bit is received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_en | input | 1 | Arms detection of a new frame |
| mp_mode | input | 1 | When 1, a frame needs a high stop bit to be kept |
| done_clr | input | 1 | Clears `rx_done` |
| rx_line | input | 1 | Asynchronous serial input, idles high |
| rx_byte | output | 8 | Data bits of the last kept frame |
| rx_bit9 | output | 1 | Ninth bit of the last kept frame |
| rx_done | output | 1 | Sticky flag: a kept frame is waiting |

## Verification
The assertions assume that `rx_line` is idle high after reset and that `tick16` pulses are at least two clocks apart. The stimulus drives the line at a falling clock edge and holds each bit for exactly sixteen tick periods of four clocks. It injects noise as a two-clock glitch, so at most one of the three mid-bit samples is corrupted. The assertions also assume that `rx_en` and `mp_mode` change only between frames, and the stimulus changes them only while the line is idle.

// File: rtl/nbrx_pkg.sv
// Shared types for the nine-bit receiver.
// Assumes: nothing beyond IEEE 1800-2017.
package nbrx_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RECV = 1'b1
    } rx_state_t;
endpackage

// File: rtl/nbrx_sync.sv
// Brings the asynchronous serial line into the clock domain and flags
// falling edges on the synchronized copy.
// Assumes: the line idles high, so the flops reset to 1.
module nbrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic fall
);
    logic [STAGES-1:0] sreg;
    logic              prev;

    // Shift the raw line through the synchronizer and remember the last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '1;
            prev <= 1'b1;
        end else begin
            sreg <= {sreg[STAGES-2:0], line_in};
            prev <= sreg[STAGES-1];
        end
    end

    // Edge and level seen by the rest of the receiver.
    always_comb begin
        line_s = sreg[STAGES-1];
        fall   = prev & ~sreg[STAGES-1];
    end
endmodule

// File: rtl/nbrx_sampler.sv
// Counts oversampling ticks within a bit and forms a three-sample majority
// around the bit middle (phases MID-1, MID, MID+1).
// Assumes: restart is a one-cycle pulse at the start edge; tick is a pulse.
module nbrx_sampler #(
    parameter int OVS = 16,
    parameter int MID = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    input  logic line,
    output logic vote_valid,
    output logic vote,
    output logic bit_end
);
    localparam int PW = $clog2(OVS);
    localparam logic [PW-1:0] PH_LAST = PW'(OVS - 1);
    localparam logic [PW-1:0] PH_A    = PW'(MID - 1);
    localparam logic [PW-1:0] PH_B    = PW'(MID);
    localparam logic [PW-1:0] PH_C    = PW'(MID + 1);

    logic [PW-1:0] phase;
    logic          s_a;
    logic          s_b;

    // Phase counter: zeroed on the start edge, wraps once per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (restart) begin
            phase <= '0;
        end else if (tick) begin
            phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
        end
    end

    // Capture the first two of the three mid-bit samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_a <= 1'b1;
            s_b <= 1'b1;
        end else if (tick && !restart) begin
            if (phase == PH_A) s_a <= line;
            if (phase == PH_B) s_b <= line;
        end
    end

    // Third sample is taken live; majority and strobes are combinational.
    always_comb begin
        vote_valid = tick && !restart && (phase == PH_C);
        bit_end    = tick && !restart && (phase == PH_LAST);
        vote       = (s_a & s_b) | (s_a & line) | (s_b & line);
    end
endmodule

// File: rtl/nbrx_frame_ctrl.sv
// Frame sequencer: confirms the start bit, shifts data LSB first, holds the
// ninth bit and applies the keep/drop rule at the stop-bit middle.
// Assumes: vote_valid and bit_end never fire in the same cycle.
module nbrx_frame_ctrl
    import nbrx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_en,
    input  logic                 mp_mode,
    input  logic                 done_clr,
    input  logic                 fall,
    input  logic                 vote_valid,
    input  logic                 vote,
    input  logic                 bit_end,
    output logic                 restart,
    output logic                 busy,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 rx_bit9,
    output logic                 rx_done
);
    localparam int IDX_W = $clog2(DATA_BITS + 3);
    localparam logic [IDX_W-1:0] IDX_START = '0;
    localparam logic [IDX_W-1:0] IDX_NINTH = IDX_W'(DATA_BITS + 1);
    localparam logic [IDX_W-1:0] IDX_STOP  = IDX_W'(DATA_BITS + 2);

    rx_state_t            state;
    logic [IDX_W-1:0]     idx;
    logic [DATA_BITS-1:0] shreg;
    logic                 nine;
    logic                 at_stop;
    logic                 accept;

    // Start detection and keep decision.
    always_comb begin
        restart = (state == ST_IDLE) && rx_en && fall;
        busy    = (state == ST_RECV);
        at_stop = busy && vote_valid && (idx == IDX_STOP);
        accept  = at_stop && !rx_done && (!mp_mode || vote);
    end

    // Sequencer: state, bit index, data shift register and ninth bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
            shreg <= '0;
            nine  <= 1'b0;
        end else if (restart) begin
            state <= ST_RECV;
            idx   <= IDX_START;
        end else if (busy && vote_valid) begin
            if (idx == IDX_START) begin
                if (vote) state <= ST_IDLE;
            end else if (idx == IDX_STOP) begin
                state <= ST_IDLE;
            end else if (idx == IDX_NINTH) begin
                nine <= vote;
            end else begin
                shreg <= {vote, shreg[DATA_BITS-1:1]};
            end
        end else if (busy && bit_end) begin
            idx <= idx + 1'b1;
        end
    end

    // Output registers load only on a kept frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte <= '0;
            rx_bit9 <= 1'b0;
        end else if (accept) begin
            rx_byte <= shreg;
            rx_bit9 <= nine;
        end
    end

    // Sticky done flag; setting takes priority over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n)        rx_done <= 1'b0;
        else if (accept)   rx_done <= 1'b1;
        else if (done_clr) rx_done <= 1'b0;
    end
endmodule

// File: rtl/nine_bit_rx.sv
// Top level of the oversampling nine-bit receiver: synchronizer, mid-bit
// majority sampler and frame sequencer.
// Assumes: tick16 is a one-cycle pulse at OVS times the bit rate.
module nine_bit_rx #(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_BITS   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick16,
    input  logic                 rx_en,
    input  logic                 mp_mode,
    input  logic                 done_clr,
    input  logic                 rx_line,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 rx_bit9,
    output logic                 rx_done
);
    localparam int MID = OVS / 2;

    logic line_s;
    logic fall;
    logic restart;
    logic busy;
    logic vote_valid;
    logic vote;
    logic bit_end;

    nbrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (rx_line),
        .line_s  (line_s),
        .fall    (fall)
    );

    nbrx_sampler #(.OVS(OVS), .MID(MID)) u_samp (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick16),
        .restart    (restart),
        .line       (line_s),
        .vote_valid (vote_valid),
        .vote       (vote),
        .bit_end    (bit_end)
    );

    nbrx_frame_ctrl #(.DATA_BITS(DATA_BITS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .mp_mode    (mp_mode),
        .done_clr   (done_clr),
        .fall       (fall),
        .vote_valid (vote_valid),
        .vote       (vote),
        .bit_end    (bit_end),
        .restart    (restart),
        .busy       (busy),
        .rx_byte    (rx_byte),
        .rx_bit9    (rx_bit9),
        .rx_done    (rx_done)
    );
endmodule

// File: rtl/nine_bit_rx_chk.sv
// Property checker for nine_bit_rx, attached by bind below.
// Assumes: it observes the top-level ports and the sequencer busy flag.
module nine_bit_rx_chk #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rx_en,
    input logic                 done_clr,
    input logic                 busy,
    input logic [DATA_BITS-1:0] rx_byte,
    input logic                 rx_bit9,
    input logic                 rx_done
);
    // R1: the cycle after reset, the outputs are in their reset state.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (rx_byte == '0 && !rx_bit9 && !rx_done && !busy));

    // R2: while disabled and idle, no frame can start.
    assert_no_start_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !rx_en) |=> !busy);

    // R7: the data outputs change only when a frame is kept while done was low.
    assert_load_only_when_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({rx_byte, rx_bit9}) |-> (rx_done && !$past(rx_done)));

    // R9: the done flag holds without a clear.
    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !done_clr) |=> rx_done);

    // R9: the done flag only falls after a clear request.
    assert_done_fall_by_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_done) |-> $past(done_clr));

    // R7: a rising done flag comes out of a frame in progress.
    assert_done_from_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> $past(busy));
endmodule

bind nine_bit_rx nine_bit_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .done_clr (done_clr),
    .busy     (busy),
    .rx_byte  (rx_byte),
    .rx_bit9  (rx_bit9),
    .rx_done  (rx_done)
);

// File: tb/tb_nine_bit_rx.sv
module tb_nine_bit_rx;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int BIT_CLKS   = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rx_en = 1'b0;
    logic       mp_mode = 1'b0;
    logic       done_clr = 1'b0;
    logic       rx_line = 1'b1;
    logic [7:0] rx_byte;
    logic       rx_bit9;
    logic       rx_done;

    int checks = 0;
    int fails  = 0;

    logic [7:0] exp_byte = 8'h00;
    logic       exp_b9   = 1'b0;
    logic       exp_done = 1'b0;

    nine_bit_rx dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick16   (tick16),
        .rx_en    (rx_en),
        .mp_mode  (mp_mode),
        .done_clr (done_clr),
        .rx_line  (rx_line),
        .rx_byte  (rx_byte),
        .rx_bit9  (rx_bit9),
        .rx_done  (rx_done)
    );

    initial forever #(CLK_PERIOD / 2) clk = ~clk;

    // Oversampling tick: one clock in every TICK_DIV, changed at the falling edge.
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            cnt = (cnt + 1) % TICK_DIV;
            tick16 = (cnt == 0);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        check({req, " byte"}, rx_byte, exp_byte);
        check({req, " bit9"}, rx_bit9, exp_b9);
        check({req, " done"}, rx_done, exp_done);
    endtask

    // One bit time on the line, with an optional two-clock glitch mid-bit.
    task automatic drive_bit(input logic v, input logic noisy);
        rx_line = v;
        repeat (34) @(negedge clk);
        if (noisy) rx_line = ~v;
        repeat (2) @(negedge clk);
        rx_line = v;
        repeat (BIT_CLKS - 36) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic b9, input logic stp,
                              input logic noisy);
        drive_bit(1'b0, noisy);
        for (int i = 0; i < 8; i++) drive_bit(d[i], noisy);
        drive_bit(b9, noisy);
        drive_bit(stp, noisy);
        rx_line = 1'b1;
    endtask

    // Model of the keep rule (R7, R8) applied after each full frame.
    task automatic model_frame(input logic [7:0] d, input logic b9, input logic stp);
        if (rx_en && !exp_done && (!mp_mode || stp)) begin
            exp_byte = d;
            exp_b9   = b9;
            exp_done = 1'b1;
        end
    endtask

    task automatic frame_and_check(input logic [7:0] d, input logic b9, input logic stp,
                                   input logic noisy, input string req);
        send_frame(d, b9, stp, noisy);
        repeat (16) @(negedge clk);
        model_frame(d, b9, stp);
        check_outputs(req);
    endtask

    task automatic clear_done;
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        @(negedge clk);
        exp_done = 1'b0;
        check("R9 clear", rx_done, 0);
    endtask

    // Watchdog: an expired run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check_outputs("R1 reset");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_outputs("R1 after release");

        // R2: frame while disabled is ignored.
        rx_en = 1'b0;
        frame_and_check(8'hA5, 1'b1, 1'b1, 1'b0, "R2 disabled");
        rx_en = 1'b1;
        repeat (8) @(negedge clk);

        // R3, R6: sweep of data values and ninth-bit values.
        for (int i = 0; i < 24; i++) begin
            logic [7:0] d;
            d = 8'(i * 37 + 5);
            frame_and_check(d, i[0], 1'b1, 1'b0, "R6 sweep");
            clear_done();
        end
        frame_and_check(8'h00, 1'b1, 1'b1, 1'b0, "R3 all zero");
        clear_done();
        frame_and_check(8'hFF, 1'b0, 1'b1, 1'b0, "R3 all one");
        clear_done();
        frame_and_check(8'h01, 1'b0, 1'b1, 1'b0, "R6 lsb first");
        clear_done();

        // R4: one glitched sample per bit is out-voted.
        frame_and_check(8'h5A, 1'b1, 1'b1, 1'b1, "R4 noise");
        clear_done();
        frame_and_check(8'hC3, 1'b0, 1'b1, 1'b1, "R4 noise");
        clear_done();

        // R5: short low pulse is a false start; next frame still received.
        rx_line = 1'b0;
        repeat (12) @(negedge clk);
        rx_line = 1'b1;
        repeat (BIT_CLKS * 12) @(negedge clk);
        check_outputs("R5 false start");
        frame_and_check(8'h3C, 1'b1, 1'b1, 1'b0, "R5 rearm");
        clear_done();

        // R8: stop-bit rule under both settings of mp_mode.
        mp_mode = 1'b1;
        frame_and_check(8'h77, 1'b1, 1'b0, 1'b0, "R8 mp low stop");
        frame_and_check(8'h78, 1'b0, 1'b1, 1'b0, "R8 mp high stop");
        clear_done();
        mp_mode = 1'b0;
        frame_and_check(8'h99, 1'b1, 1'b0, 1'b0, "R8 no mp low stop");
        repeat (BIT_CLKS) @(negedge clk);
        clear_done();

        // R7: pending done blocks the next frame.
        frame_and_check(8'h12, 1'b0, 1'b1, 1'b0, "R7 first");
        frame_and_check(8'h34, 1'b1, 1'b1, 1'b0, "R7 blocked");
        clear_done();

        // R10, R9: back-to-back frames with the clear held; set beats clear.
        done_clr = 1'b1;
        send_frame(8'hE1, 1'b1, 1'b1, 1'b0);
        send_frame(8'h1E, 1'b0, 1'b1, 1'b0);
        repeat (16) @(negedge clk);
        check("R10 back-to-back byte", rx_byte, 8'h1E);
        check("R10 back-to-back bit9", rx_bit9, 0);
        check("R9 cleared after set", rx_done, 0);
        done_clr = 1'b0;
        exp_byte = 8'h1E;
        exp_b9   = 1'b0;
        exp_done = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule